// File: doc/BRIEF.md
# Predicated Vector Reduction Engine

This block folds a vector of up to `MAX_VL` elements into one scalar using add, multiply or bitwise OR. A `start_i` pulse while the block is idle loads the vector length, a per-element enable mask, the operation, a record flag and a condition-merge select. After that the elements arrive one per cycle on `elem_i`, qualified by `elem_valid_i`, in ascending index order. Elements whose mask bit is clear are skipped. The first enabled element seeds the accumulator, and every later enabled element is folded into it in index order.

When the last element has been accepted, the block pulses `done_o`. With that pulse it presents the scalar result and the index of the lowest enabled element, which is the destination slot the result is written to. When record mode is on, it also presents a 4-bit condition field. That field is built by analysing every partial result as a signed value and merging the outcomes, either as "some partial result met the test" or as "all partial results met it". If no element is enabled, the block raises a no-result flag and reports nothing else.

Top module: `vec_mapreduce`

## Requirements
- R1: A `start_i` pulse while `busy_o` is low captures `vl_i`, `mask_i`, `op_i`, `rec_i` and `crm_i`, and `busy_o` rises in the next cycle when `vl_i` is nonzero. A `start_i` pulse while `busy_o` is high has no effect on the running reduction.
- R2: `op_i` encoding: 2'b00 adds modulo 2^W, 2'b01 multiplies and keeps the low W bits of the product, and 2'b10 and 2'b11 both apply bitwise OR.
- R3: While busy, one element is accepted on each clock edge at which `elem_valid_i` is high, and the accepted elements take indices 0, 1, 2 and so on. Cycles with `elem_valid_i` low are stalls. `elem_valid_i` while idle changes no output.
- R4: An element whose bit in `mask_i` (bit i for element i) is 0 is skipped. The result is the left fold, in index order, of the enabled elements, starting from the first enabled one.
- R5: `dest_idx_o` is the index of the lowest enabled element below the effective vector length, and `result_o` holds the reduced value.
- R6: `done_o` is high for exactly one cycle: the cycle after the edge that accepted element VL-1, or the cycle after the accepting `start_i` when VL is 0. `busy_o` is low from that cycle on.
- R7: When no element below VL is enabled (VL = 0 included), `no_result_o` is high with `done_o`, and `result_o`, `dest_idx_o` and `cond_o` are all 0.
- R8: Condition format: bit 3 is set when the partial result is negative as a signed W-bit value, bit 2 when it is positive, bit 1 when it is zero, and bit 0 is always 0. The first partial result is the first enabled element, and each fold produces one more.
- R9: With `crm_i` = 0 the condition fields of the partial results are merged by bitwise OR. With `crm_i` = 1 they are merged by bitwise AND.
- R10: With `rec_i` = 0, `cond_o` stays 0.
- R11: A `vl_i` above `MAX_VL` acts as `MAX_VL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a reduction (used only when idle) |
| vl_i | input | VLW | Vector length |
| mask_i | input | MAX_VL | Per-element enable bits |
| op_i | input | 2 | Operation select |
| rec_i | input | 1 | Record mode: build the condition field |
| crm_i | input | 1 | Condition merge: 0 any, 1 all |
| elem_valid_i | input | 1 | Element present on elem_i |
| elem_i | input | W | Element value |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| no_result_o | output | 1 | No element was enabled (valid with done_o) |
| result_o | output | W | Reduced scalar |
| dest_idx_o | output | IW | Destination element index |
| cond_o | output | 4 | Accumulated condition field |

## Verification
The bench builds the block with `MAX_VL` = 16 and `W` = 16. The 16-bit width lets small products wrap and lets sums cross zero and the sign boundary, which exercises every condition bit and both merge rules. The vector length of 16 makes a full-length vector and a request above the maximum (VL = 20) short enough to run many times. The mask is wide enough to place the first enabled element anywhere, including at the top index.

// File: rtl/vmr_pkg.sv
package vmr_pkg;

    typedef enum logic [1:0] {
        VMR_ADD    = 2'b00,
        VMR_MUL    = 2'b01,
        VMR_OR     = 2'b10,
        VMR_OR_ALT = 2'b11
    } vmr_op_e;

    typedef enum logic {
        VMR_IDLE = 1'b0,
        VMR_RUN  = 1'b1
    } vmr_state_e;

    // Bit positions inside the 4-bit condition field
    localparam int CF_NEG  = 3;
    localparam int CF_POS  = 2;
    localparam int CF_ZERO = 1;
    localparam int CF_OVF  = 0;

endpackage

// File: rtl/vmr_alu.sv
module vmr_alu
    import vmr_pkg::*;
#(
    parameter int W = 32
) (
    input  vmr_op_e        op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   y_o
);
    always_comb begin
        unique case (op_i)
            VMR_ADD:    y_o = a_i + b_i;
            VMR_MUL:    y_o = a_i * b_i;
            VMR_OR,
            VMR_OR_ALT: y_o = a_i | b_i;
            default:    y_o = a_i | b_i;
        endcase
    end
endmodule

// File: rtl/vmr_flags.sv
module vmr_flags
    import vmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    output logic [3:0]   cf_o
);
    logic is_neg;
    logic is_zero;

    assign is_neg  = val_i[W-1];
    assign is_zero = (val_i == '0);

    always_comb begin
        cf_o          = '0;
        cf_o[CF_NEG]  = is_neg;
        cf_o[CF_POS]  = !is_neg && !is_zero;
        cf_o[CF_ZERO] = is_zero;
        cf_o[CF_OVF]  = 1'b0;
    end
endmodule

// File: rtl/vmr_cf_merge.sv
module vmr_cf_merge (
    input  logic       all_i,
    input  logic [3:0] acc_i,
    input  logic [3:0] new_i,
    output logic [3:0] out_o
);
    assign out_o = all_i ? (acc_i & new_i) : (acc_i | new_i);
endmodule

// File: rtl/vec_mapreduce.sv
module vec_mapreduce
    import vmr_pkg::*;
#(
    parameter  int MAX_VL = 64,
    parameter  int W      = 32,
    localparam int VLW    = $clog2(MAX_VL + 1),
    localparam int IW     = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VLW-1:0]    vl_i,
    input  logic [MAX_VL-1:0] mask_i,
    input  logic [1:0]        op_i,
    input  logic              rec_i,
    input  logic              crm_i,
    input  logic              elem_valid_i,
    input  logic [W-1:0]      elem_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              no_result_o,
    output logic [W-1:0]      result_o,
    output logic [IW-1:0]     dest_idx_o,
    output logic [3:0]        cond_o
);
    localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);

    typedef struct packed {
        vmr_state_e        st;
        logic [VLW-1:0]    vl;
        logic [MAX_VL-1:0] mask;
        vmr_op_e           op;
        logic              rec;
        logic              crm;
        logic [IW-1:0]     idx;
        logic              have;
        logic [W-1:0]      acc;
        logic [IW-1:0]     dest;
        logic [3:0]        cf;
        logic              done;
    } regs_t;

    regs_t q, d;

    logic [W-1:0] fold_val;
    logic [3:0]   fold_cf;
    logic [3:0]   seed_cf;
    logic [3:0]   merged_cf;
    logic         elem_on;
    logic         last_elem;

    vmr_alu #(.W(W)) u_alu (
        .op_i (q.op),
        .a_i  (q.acc),
        .b_i  (elem_i),
        .y_o  (fold_val)
    );

    vmr_flags #(.W(W)) u_flags_fold (
        .val_i (fold_val),
        .cf_o  (fold_cf)
    );

    vmr_flags #(.W(W)) u_flags_seed (
        .val_i (elem_i),
        .cf_o  (seed_cf)
    );

    vmr_cf_merge u_merge (
        .all_i (q.crm),
        .acc_i (q.cf),
        .new_i (fold_cf),
        .out_o (merged_cf)
    );

    assign elem_on   = q.mask[q.idx];
    assign last_elem = ((VLW'(q.idx) + VLW'(1)) == q.vl);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            VMR_IDLE: begin
                if (start_i) begin
                    d.vl   = (vl_i > VL_CAP) ? VL_CAP : vl_i;
                    d.mask = mask_i;
                    d.op   = vmr_op_e'(op_i);
                    d.rec  = rec_i;
                    d.crm  = crm_i;
                    d.idx  = '0;
                    d.have = 1'b0;
                    d.acc  = '0;
                    d.dest = '0;
                    d.cf   = '0;
                    if (vl_i == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st = VMR_RUN;
                    end
                end
            end
            VMR_RUN: begin
                if (elem_valid_i) begin
                    if (elem_on) begin
                        if (!q.have) begin
                            d.acc  = elem_i;
                            d.dest = q.idx;
                            d.have = 1'b1;
                            if (q.rec) d.cf = seed_cf;
                        end else begin
                            d.acc = fold_val;
                            if (q.rec) d.cf = merged_cf;
                        end
                    end
                    if (last_elem) begin
                        d.st   = VMR_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + IW'(1);
                    end
                end
            end
            default: d.st = VMR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st == VMR_RUN);
    assign done_o      = q.done;
    assign no_result_o = q.done && !q.have;
    assign result_o    = q.acc;
    assign dest_idx_o  = q.dest;
    assign cond_o      = q.cf;

endmodule

// File: rtl/vec_mapreduce_chk.sv
module vec_mapreduce_chk #(
    parameter  int MAX_VL = 64,
    parameter  int W      = 32,
    localparam int VLW    = $clog2(MAX_VL + 1),
    localparam int IW     = $clog2(MAX_VL)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [VLW-1:0]    vl_i,
    input logic [MAX_VL-1:0] mask_i,
    input logic              rec_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              no_result_o,
    input logic [W-1:0]      result_o,
    input logic [IW-1:0]     dest_idx_o,
    input logic [3:0]        cond_o
);
    localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);

    logic              rec_cap;
    logic [VLW-1:0]    vl_cap;
    logic [MAX_VL-1:0] mask_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_cap  <= 1'b0;
            vl_cap   <= '0;
            mask_cap <= '0;
        end else if (start_i && !busy_o) begin
            rec_cap  <= rec_i;
            vl_cap   <= (vl_i > VL_CAP) ? VL_CAP : vl_i;
            mask_cap <= mask_i;
        end
    end

    assert_busy_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && vl_i != '0) |=> busy_o);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(result_o) && $stable(cond_o) && $stable(dest_idx_o)));

    assert_dest_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !no_result_o) |-> (mask_cap[dest_idx_o] && (VLW'(dest_idx_o) < vl_cap)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_empty_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        no_result_o |-> (result_o == '0 && dest_idx_o == '0 && cond_o == '0));

    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_o[0]);

    assert_no_record_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !rec_cap) |-> (cond_o == '0));

endmodule

bind vec_mapreduce vec_mapreduce_chk #(.MAX_VL(MAX_VL), .W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .vl_i        (vl_i),
    .mask_i      (mask_i),
    .rec_i       (rec_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .no_result_o (no_result_o),
    .result_o    (result_o),
    .dest_idx_o  (dest_idx_o),
    .cond_o      (cond_o)
);

// File: tb/vec_mapreduce_tb.sv
`timescale 1ns/1ps
module vec_mapreduce_tb;
    localparam int BVL  = 16;
    localparam int BW   = 16;
    localparam int BVLW = $clog2(BVL + 1);
    localparam int BIW  = $clog2(BVL);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [BVLW-1:0] vl_i = '0;
    logic [BVL-1:0]  mask_i = '0;
    logic [1:0]      op_i = '0;
    logic            rec_i = 1'b0;
    logic            crm_i = 1'b0;
    logic            elem_valid_i = 1'b0;
    logic [BW-1:0]   elem_i = '0;
    logic            busy_o;
    logic            done_o;
    logic            no_result_o;
    logic [BW-1:0]   result_o;
    logic [BIW-1:0]  dest_idx_o;
    logic [3:0]      cond_o;

    always #2.5 clk = ~clk;

    vec_mapreduce #(.MAX_VL(BVL), .W(BW)) u_dut (.*);

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [BW-1:0] elems [BVL];
    logic [BW-1:0] got_res;
    int            got_dest;
    logic [3:0]    got_cf;
    bit            got_none;
    int            got_lat;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail   = n_fail + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] flg(input logic [BW-1:0] v);
        logic [3:0] f;
        f    = '0;
        f[3] = v[BW-1];
        f[1] = (v == '0);
        f[2] = !v[BW-1] && (v != '0);
        return f;
    endfunction

    function automatic logic [BW-1:0] gen(input int seed, input int i);
        return BW'(seed * (i + 3)) - BW'(40);
    endfunction

    task automatic model(input int vl, input logic [BVL-1:0] m, input logic [1:0] op,
                         input bit rec, input bit crm,
                         output logic [BW-1:0] res, output int dest,
                         output logic [3:0] cf, output bit none);
        int n;
        bit have;
        n = (vl > BVL) ? BVL : vl;
        have = 0; res = '0; dest = 0; cf = '0;
        for (int i = 0; i < n; i++) begin
            if (m[i]) begin
                if (!have) begin
                    res = elems[i]; dest = i; have = 1;
                    if (rec) cf = flg(res);
                end else begin
                    if (op == 2'b00)      res = res + elems[i];
                    else if (op == 2'b01) res = res * elems[i];
                    else                  res = res | elems[i];
                    if (rec) cf = crm ? (cf & flg(res)) : (cf | flg(res));
                end
            end
        end
        none = !have;
    endtask

    // Drives one reduction; poke raises start_i again while busy
    task automatic run(input int vl, input logic [BVL-1:0] m, input logic [1:0] op,
                       input bit rec, input bit crm, input int gap, input bit poke);
        int n;
        n = (vl > BVL) ? BVL : vl;
        @(negedge clk);
        start_i = 1'b1; vl_i = BVLW'(vl); mask_i = m; op_i = op; rec_i = rec; crm_i = crm;
        @(negedge clk);
        start_i = 1'b0; vl_i = '0; mask_i = '0; rec_i = 1'b0; op_i = 2'b00;
        for (int i = 0; i < n; i++) begin
            for (int g = 0; g < gap; g++) begin
                elem_valid_i = 1'b0; elem_i = 16'hDEAD;
                @(negedge clk);
            end
            elem_valid_i = 1'b1; elem_i = elems[i];
            start_i = (poke && i == 1);
            @(negedge clk);
            start_i = 1'b0;
        end
        elem_valid_i = 1'b0;
        got_lat = 0;
        while (!done_o && got_lat < 50) begin
            @(negedge clk);
            got_lat++;
        end
        got_res = result_o; got_dest = dest_idx_o; got_cf = cond_o; got_none = no_result_o;
    endtask

    typedef struct packed {
        logic [4:0]  vl;
        logic [15:0] mask;
        logic [1:0]  op;
        logic        rec;
        logic        crm;
        logic [7:0]  seed;
        logic [1:0]  gap;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VTAB [NV] = '{
        '{5'd16, 16'hFFFF, 2'b00, 1'b1, 1'b0, 8'd7,   2'd0},
        '{5'd16, 16'hFFFF, 2'b00, 1'b1, 1'b1, 8'd13,  2'd0},
        '{5'd9,  16'h01A4, 2'b01, 1'b1, 1'b0, 8'd3,   2'd1},
        '{5'd12, 16'h0F0F, 2'b01, 1'b1, 1'b1, 8'd251, 2'd0},
        '{5'd16, 16'h8001, 2'b10, 1'b1, 1'b0, 8'd90,  2'd2},
        '{5'd7,  16'h0055, 2'b11, 1'b0, 1'b0, 8'd17,  2'd0},
        '{5'd16, 16'h8000, 2'b00, 1'b1, 1'b1, 8'd5,   2'd0},
        '{5'd3,  16'hFFF8, 2'b00, 1'b1, 1'b0, 8'd9,   2'd1},
        '{5'd20, 16'hAAAA, 2'b00, 1'b1, 1'b0, 8'd33,  2'd0},
        '{5'd10, 16'h03FF, 2'b01, 1'b0, 1'b1, 8'd2,   2'd0}
    };

    initial begin
        logic [BW-1:0] e_res;
        int            e_dest;
        logic [3:0]    e_cf;
        bit            e_none;
        logic [BW-1:0] held;

        #12 rst_n = 1'b1;
        @(negedge clk);
        // R6 R7 reset state
        chk("R6 reset busy", 32'(busy_o), 0);
        chk("R6 reset done", 32'(done_o), 0);
        chk("R7 reset result", 32'(result_o), 0);
        chk("R10 reset cond", 32'(cond_o), 0);

        // Table walk: R2 R4 R5 R8 R9 R11 against the bench model
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < BVL; i++) elems[i] = gen(int'(VTAB[v].seed), i);
            model(int'(VTAB[v].vl), VTAB[v].mask, VTAB[v].op, VTAB[v].rec, VTAB[v].crm,
                  e_res, e_dest, e_cf, e_none);
            run(int'(VTAB[v].vl), VTAB[v].mask, VTAB[v].op, VTAB[v].rec, VTAB[v].crm,
                int'(VTAB[v].gap), 1'b0);
            chk($sformatf("R4 table %0d result", v), 32'(got_res), 32'(e_res));
            chk($sformatf("R5 table %0d dest", v), 32'(got_dest), 32'(e_dest));
            chk($sformatf("R9 table %0d cond", v), 32'(got_cf), 32'(e_cf));
            chk($sformatf("R6 table %0d latency", v), 32'(got_lat), 0);
        end

        // R7 VL of zero
        run(0, 16'hFFFF, 2'b00, 1'b1, 1'b0, 0, 1'b0);
        chk("R7 vl0 none", 32'(got_none), 1);
        chk("R7 vl0 result", 32'(got_res), 0);
        @(negedge clk);
        chk("R6 pulse width", 32'(done_o), 0);

        // R7 nothing enabled
        for (int i = 0; i < BVL; i++) elems[i] = 16'h1234;
        run(8, 16'h0000, 2'b00, 1'b1, 1'b0, 0, 1'b0);
        chk("R7 masked none", 32'(got_none), 1);
        chk("R7 masked result", 32'(got_res), 0);
        chk("R7 masked cond", 32'(got_cf), 0);

        // R8 single enabled negative element at index 5
        elems[5] = 16'hFFFD;
        run(8, 16'h0020, 2'b00, 1'b1, 1'b0, 0, 1'b0);
        chk("R5 single dest", 32'(got_dest), 5);
        chk("R8 single result", 32'(got_res), 32'h0000FFFD);
        chk("R8 negative cond", 32'(got_cf), 32'h8);

        // R9 partials 5 (positive) then 0 (zero)
        elems[0] = 16'd5; elems[1] = 16'hFFFB;
        run(2, 16'h0003, 2'b00, 1'b1, 1'b0, 0, 1'b0);
        chk("R9 any merge", 32'(got_cf), 32'h6);
        chk("R2 add to zero", 32'(got_res), 0);
        run(2, 16'h0003, 2'b00, 1'b1, 1'b1, 0, 1'b0);
        chk("R9 all merge", 32'(got_cf), 32'h0);

        // R2 multiply wraps, R10 no record
        elems[0] = 16'd300; elems[1] = 16'd300;
        run(2, 16'h0003, 2'b01, 1'b0, 1'b0, 0, 1'b0);
        chk("R2 mul wrap", 32'(got_res), 32'd24464);
        chk("R10 no record", 32'(got_cf), 0);

        // R2 code 11 is OR
        elems[0] = 16'h00F0; elems[1] = 16'h000F;
        run(2, 16'h0003, 2'b11, 1'b1, 1'b0, 0, 1'b0);
        chk("R2 alt or", 32'(got_res), 32'h00FF);

        // R4 disabled elements skipped
        elems[0] = 16'd1; elems[1] = 16'd2; elems[2] = 16'd3; elems[3] = 16'd4;
        run(4, 16'h000A, 2'b00, 1'b1, 1'b0, 0, 1'b0);
        chk("R4 skip add", 32'(got_res), 6);
        chk("R5 skip dest", 32'(got_dest), 1);
        elems[0] = 16'd2; elems[1] = 16'd9; elems[2] = 16'd3; elems[3] = 16'd5;
        run(4, 16'h000D, 2'b01, 1'b1, 1'b0, 0, 1'b0);
        chk("R4 skip mul", 32'(got_res), 30);

        // R11 length above maximum
        for (int i = 0; i < BVL; i++) elems[i] = 16'd1;
        run(20, 16'hFFFF, 2'b00, 1'b0, 1'b0, 0, 1'b0);
        chk("R11 capped sum", 32'(got_res), 16);
        chk("R11 capped latency", 32'(got_lat), 0);

        // R1 start while busy ignored (vl 0 poke would end it early)
        run(4, 16'hFFFF, 2'b00, 1'b0, 1'b0, 0, 1'b1);
        chk("R1 poke result", 32'(got_res), 4);
        chk("R1 poke latency", 32'(got_lat), 0);

        // R3 element valid while idle changes nothing
        held = result_o;
        @(negedge clk);
        elem_valid_i = 1'b1; elem_i = 16'h7777;
        @(negedge clk);
        @(negedge clk);
        elem_valid_i = 1'b0;
        chk("R3 idle result", 32'(result_o), 32'(held));
        chk("R3 idle done", 32'(done_o), 0);
        chk("R3 idle busy", 32'(busy_o), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule